// File: doc/BRIEF.md
# Strided Address Sequence Expander

This block turns one compact run descriptor into a stream of values that form an arithmetic progression. A descriptor carries a starting value, a stride and a repeat count. The block takes one descriptor at a time over a valid/ready input. It presents the starting value first. Each later value is the previous one plus the stride. The repeat count is the number of strides that follow the starting value, so a descriptor always yields count + 1 values.

The block is meant to sit in front of a configuration write port and rebuild address sequences that were packed on the host side. Every output value travels over a valid/ready handshake. A stalled consumer freezes the sequence without losing a value.

Control is a two-state machine:
- **ST_IDLE**: the input is ready and no output is offered. Transition **T_ACCEPT** (input valid) moves it to ST_EMIT. On that edge the value register loads the starting value and the stride register loads the stride. The down counter loads the count.
- **ST_EMIT**: the output is valid and the input is not ready. Transition **T_STEP** happens when the consumer takes a value while the counter is non-zero. It adds the stride and decrements the counter, and the state stays in ST_EMIT. Transition **T_DONE** happens when the consumer takes a value while the counter is zero. It returns the block to ST_IDLE.

Top module: `stride_seq_expander`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A descriptor is taken only in ST_IDLE. in_ready is 0 for as long as a run is being emitted. in_valid asserted during a run has no effect on the values emitted.
- R3: The first value offered after a descriptor is taken equals in_base as it was sampled on the accepting edge.
- R4: Each value after the first equals the previous value plus the stride, modulo 2^VAL_W.
- R5: A descriptor with count n produces exactly n + 1 transfers. in_ready returns to 1 in the cycle after the last transfer.
- R6: A count of zero produces exactly one transfer, the starting value.
- R7: While out_valid is 1 and out_ready is 0, out_value and the remaining count are held.
- R8: The stride and count are sampled only on the accepting edge. Changes to in_offset, in_length or in_base during a run do not affect the values emitted.
- R9: The largest count, 2^CNT_W - 1, yields 2^CNT_W values with no early end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Block can take a descriptor (ST_IDLE) |
| in_base | input | VAL_W | Starting value of the run |
| in_offset | input | VAL_W | Stride added for each later value |
| in_length | input | CNT_W | Number of strides after the starting value |
| out_valid | output | 1 | A value is offered |
| out_ready | input | 1 | Consumer takes the offered value |
| out_value | output | VAL_W | Current value of the progression |

## Verification
The bench targets four corner cases:
- **Count of zero.** An off-by-one in the down counter would emit two values here, or one value fewer on every other run.
- **Sums that pass the top of the value range.** A design that saturated instead of wrapping would diverge as soon as the sum passes the top.
- **Random consumer stalls.** A design that advanced without checking out_ready would skip values.
- **Descriptors that change or stay valid during a run.** A design that read the fields live, or accepted while busy, would mix two runs.

The maximum count is run to show that the counter does not wrap or end early.

// File: rtl/sse_pkg.sv
package sse_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } sse_state_e;

endpackage

// File: rtl/sse_ctrl.sv
module sse_ctrl
    import sse_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    input  logic cnt_zero,
    output logic in_ready,
    output logic out_valid,
    output logic load,
    output logic step_en
);

    sse_state_e state_q;
    sse_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: T_ACCEPT, T_STEP, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)              state_d = ST_EMIT;
            ST_EMIT: if (out_ready && cnt_zero) state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load      = 1'b0;
        step_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                load     = in_valid;
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                step_en   = out_ready && !cnt_zero;
            end
            default: ;
        endcase
    end

    AST_HANDSHAKE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid)); // R2

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && cnt_zero) |=> in_ready); // R5

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (out_valid && !in_ready)); // R2

endmodule

// File: rtl/sse_value_acc.sv
module sse_value_acc #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step_en,
    input  logic [VAL_W-1:0] base_i,
    input  logic [VAL_W-1:0] offset_i,
    output logic [VAL_W-1:0] value_o
);

    logic [VAL_W-1:0] val_q;
    logic [VAL_W-1:0] off_q;
    logic [VAL_W-1:0] sum;

    // modulo 2^VAL_W by truncation
    assign sum = val_q + off_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            off_q <= '0;
        end else if (load) begin
            val_q <= base_i;
            off_q <= offset_i;
        end else if (step_en) begin
            val_q <= sum;
        end
    end

    assign value_o = val_q;

    AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (val_q == $past(base_i))); // R3

    AST_STRIDE_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (val_q == VAL_W'($past(val_q) + $past(off_q)))); // R4

    AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_en) |=> $stable(val_q)); // R7

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(off_q)); // R8

endmodule

// File: rtl/sse_down_cnt.sv
module sse_down_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] len_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len_i;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0)); // R9

    AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R5

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !load) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/stride_seq_expander.sv
module stride_seq_expander #(
    parameter int VAL_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VAL_W-1:0] in_base,
    input  logic [VAL_W-1:0] in_offset,
    input  logic [CNT_W-1:0] in_length,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VAL_W-1:0] out_value
);

    logic load;
    logic step_en;
    logic cnt_zero;

    sse_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .cnt_zero  (cnt_zero),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load),
        .step_en   (step_en)
    );

    sse_value_acc #(.VAL_W(VAL_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step_en  (step_en),
        .base_i   (in_base),
        .offset_i (in_offset),
        .value_o  (out_value)
    );

    sse_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .dec    (step_en),
        .len_i  (in_length),
        .zero_o (cnt_zero)
    );

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_value)); // R7

endmodule

// File: tb/stride_seq_expander_test.sv
module stride_seq_expander_test;

    localparam int VW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [VW-1:0] in_base = '0;
    logic [VW-1:0] in_offset = '0;
    logic [CW-1:0] in_length = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [VW-1:0] out_value;

    always #4 clk = ~clk; // 125 MHz

    stride_seq_expander #(.VAL_W(VW), .CNT_W(CW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_base   (in_base),
        .in_offset (in_offset),
        .in_length (in_length),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_value (out_value)
    );

    int            checks = 0;
    int            fails = 0;
    int            cycle = 0;
    string         cur_req = "R1";
    logic [VW-1:0] got[$];
    int            rdy_mode = 0;
    logic [15:0]   lfsr = 16'hACE1;

    // behavioural reference model
    bit            m_busy = 0;
    logic [VW-1:0] m_val = '0;
    logic [VW-1:0] m_step = '0;
    int            m_left = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0;
        end else if (!m_busy) begin
            if (in_valid) begin
                m_busy = 1;
                m_val  = in_base;
                m_step = in_offset;
                m_left = int'(in_length);
            end
        end else if (out_ready) begin
            if (m_left == 0) begin
                m_busy = 0;
            end else begin
                m_val  = m_val + m_step;
                m_left = m_left - 1;
            end
        end
    end

    // consumer readiness pattern
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rdy_mode == 0) out_ready = 1'b1;
        else               out_ready = lfsr[0] | lfsr[3];
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycle++;
        if (cycle > 150000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycle, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
        if (rst_n) begin
            chk(in_ready == !m_busy, cur_req, "in_ready vs model", in_ready, !m_busy);
            chk(out_valid == m_busy, cur_req, "out_valid vs model", out_valid, m_busy);
            if (m_busy)
                chk(out_value == m_val, cur_req, "out_value vs model", out_value, m_val);
            if (out_valid && out_ready) got.push_back(out_value);
        end
    end

    task automatic run(input string req, input logic [VW-1:0] b,
                       input logic [VW-1:0] s, input logic [CW-1:0] n,
                       input bit junk);
        logic [VW-1:0] e;
        cur_req = req;
        @(posedge clk); #1;
        got.delete();
        in_base   = b;
        in_offset = s;
        in_length = n;
        in_valid  = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        if (junk) begin
            // R2 R8: descriptor lines disturbed while the run is going
            in_base   = 16'hDEAD;
            in_offset = 16'h0BAD;
            in_length = 8'h03;
            repeat (5) @(posedge clk);
            #1;
        end
        in_valid  = 1'b0;
        in_base   = ~b;
        in_offset = ~s;
        in_length = ~n;
        while (got.size() < int'(n) + 1) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(got.size() == int'(n) + 1, req, "transfer count", got.size(), int'(n) + 1);
        chk(in_ready == 1'b1, "R5", "in_ready after run", in_ready, 1);
        e = b;
        for (int k = 0; k < got.size() && k <= int'(n); k++) begin
            chk(got[k] == e, (k == 0) ? "R3" : req, "value in run", got[k], e);
            e = e + s;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "idle after reset",
            {in_ready, out_valid}, 2'b10);

        run("R4", 16'd100, 16'd3, 8'd4, 0);           // 100..112
        run("R6", 16'h0042, 16'h1111, 8'd0, 0);       // base only
        run("R4", 16'hFFF0, 16'h0007, 8'd5, 0);       // wraps past top
        rdy_mode = 1;
        run("R7", 16'h1234, 16'h0101, 8'd20, 0);      // random stalls
        run("R6", 16'h7777, 16'h0001, 8'd0, 0);       // zero count under stall
        rdy_mode = 0;
        run("R2", 16'h0500, 16'h0010, 8'd12, 1);      // R8 junk during run
        run("R9", 16'h0000, 16'h0123, 8'd255, 0);     // max count
        rdy_mode = 1;
        run("R8", 16'hABCD, 16'hFFFF, 8'd9, 1);       // negative stride, stalls

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule